// File: doc/BRIEF.md
# MSI Snooping Cache Coherence Controller

This block keeps a small direct-mapped private write-back data cache coherent with its peers on a shared snooping bus. Every line carries one of three coherence states: Invalid, Shared (a clean read-only copy that other caches may also hold) or Modified (the only copy, and dirty). Processor loads and stores arrive on one side. Bus transactions issued by other caches are observed on the other side. The controller decides which requests it can serve locally and which ones need a bus transaction.

When a bus transaction is needed, the controller raises a request, waits for a one-cycle grant, and in the grant cycle drives the transaction type, the block address and, for a write back, the block data. For a read miss or write miss, the block then arrives on a separate fill input. When another cache misses on a line held Modified here, the controller places the block on a supply output in the next cycle. Memory and the requesting cache both take it from there. The processor holds its request stable until the controller raises a one-cycle ready pulse.

Blocks are one data word wide. The line index is the low IDX_W bits of the address, and the rest of the address is the tag.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: On reset every line becomes Invalid, and cpu_ready, bus_req and snp_sup_valid are low. After reset, the first read of any address issues a read miss.
- R2: A read of a line that is not present issues a read miss (type code 0) and completes with the fill data. The line is then Shared, so a later read of it completes without a bus request.
- R3: A write that hits a Shared line issues an invalidate (type code 2) and completes in the cycle after the invalidate is on the bus. The line then holds the written word as Modified.
- R4: A read hit on a Shared or Modified line, and a write hit on a Modified line, complete without a bus request. A read returns the last word written to that address.
- R5: A miss whose line holds a Modified block of another address first issues a write back (type code 3) carrying that block's data, then the miss. A write miss (type code 1) ignores the fill data, keeps the write data and leaves the line Modified.
- R6: A snooped read miss that hits a Modified line puts the line's data on snp_sup_data with snp_sup_valid high in the next cycle, and drops the line to Shared, so a later local write needs an invalidate.
- R7: A snooped write miss that hits a Modified line supplies the data in the same way and leaves the line Invalid. A snooped invalidate or write miss that hits a Shared line makes it Invalid without a supply. In each case the next local read misses.
- R8: A snoop whose tag does not match, a snoop that finds the line Invalid, and a snooped read miss on a Shared line change nothing and supply nothing.
- R9: In a cycle with snp_valid high, no bus transaction is driven even when granted, and no new processor request is taken. If such a snoop hits the index of a request that is waiting for the bus, the request is decided again, so a pending upgrade whose line was invalidated becomes a write miss.
- R10: bus_req stays high from the cycle the bus is needed until a grant that is not pre-empted by a snoop, and cpu_ready is low while bus_req is high.
- R11: cpu_ready is a single-cycle pulse per completed request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present, held until cpu_ready |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address of the request |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_ready |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | One-cycle bus grant |
| bus_cmd_valid | output | 1 | Transaction driven this cycle |
| bus_cmd_type | output | 2 | 0 read miss, 1 write miss, 2 invalidate, 3 write back |
| bus_cmd_addr | output | ADDR_W | Block address of the transaction |
| bus_cmd_data | output | DATA_W | Block data for a write back |
| fill_valid | input | 1 | Block for the outstanding miss is present |
| fill_data | input | DATA_W | Block data for the outstanding miss |
| snp_valid | input | 1 | Another cache's transaction is observed |
| snp_type | input | 2 | Type of the observed transaction, same codes |
| snp_addr | input | ADDR_W | Block address of the observed transaction |
| snp_sup_valid | output | 1 | Block supplied to the bus |
| snp_sup_data | output | DATA_W | Supplied block data |

## Verification
A grant to this cache and a snooped transaction can arrive in the same cycle. The case that matters is when a store upgrade is waiting for the bus on a Shared line and another cache's invalidate for that line is observed together with the grant. The bench raises bus_gnt and an invalidate snoop in one cycle while the upgrade request is high. It then checks that no transaction is driven in that cycle, that the retried store comes out as a write miss rather than an invalidate, and that a later load returns the stored word from a hit. A second collision presents a load and an unrelated snoop together and checks that completion is delayed by exactly the snoop cycle.

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_cmd_valid,
  output logic [1:0]        bus_cmd_type,
  output logic [ADDR_W-1:0] bus_cmd_addr,
  output logic [DATA_W-1:0] bus_cmd_data,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              snp_valid,
  input  logic [1:0]        snp_type,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_sup_valid,
  output logic [DATA_W-1:0] snp_sup_data
);

  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;
  localparam logic [1:0] T_RD  = 2'd0;
  localparam logic [1:0] T_WR  = 2'd1;
  localparam logic [1:0] T_INV = 2'd2;
  localparam logic [1:0] T_WB  = 2'd3;

  typedef enum logic [1:0] {L_I, L_S, L_M} line_st_t;
  typedef enum logic [2:0] {F_IDLE, F_WB, F_MISS, F_FILL, F_UPG} fsm_t;

  line_st_t          st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];
  fsm_t              fsm_q;
  logic              done_q;

  logic [IDX_W-1:0] c_idx, s_idx;
  logic [TAG_W-1:0] c_tag, s_tag;
  line_st_t         c_st, s_st;
  logic             c_hit, s_hit;
  logic             snp_own_m, snp_take, issue, abort, accept;

  assign c_idx = cpu_req_addr[IDX_W-1:0];
  assign c_tag = cpu_req_addr[ADDR_W-1:IDX_W];
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];
  assign c_st  = st_q[c_idx];
  assign s_st  = st_q[s_idx];
  assign c_hit = (c_st != L_I) && (tag_q[c_idx] == c_tag);
  assign s_hit = (s_st != L_I) && (tag_q[s_idx] == s_tag);

  assign snp_own_m = snp_valid && s_hit && (s_st == L_M);
  assign snp_take  = snp_own_m && (snp_type == T_RD || snp_type == T_WR);

  assign bus_req = (fsm_q == F_WB) || (fsm_q == F_MISS) || (fsm_q == F_UPG);
  assign issue   = bus_req && bus_gnt && !snp_valid;
  assign abort   = snp_valid && (s_idx == c_idx);
  assign accept  = (fsm_q == F_IDLE) && cpu_req_valid && !done_q && !snp_valid;

  assign bus_cmd_valid = issue;
  assign bus_cmd_addr  = (fsm_q == F_WB) ? {tag_q[c_idx], c_idx} : cpu_req_addr;
  assign bus_cmd_data  = dat_q[c_idx];
  assign cpu_ready     = done_q;

  always_comb begin
    case (fsm_q)
      F_WB:    bus_cmd_type = T_WB;
      F_UPG:   bus_cmd_type = T_INV;
      default: bus_cmd_type = cpu_req_write ? T_WR : T_RD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q         <= F_IDLE;
      done_q        <= 1'b0;
      cpu_rdata     <= '0;
      snp_sup_valid <= 1'b0;
      snp_sup_data  <= '0;
      for (int i = 0; i < LINES; i++) st_q[i] <= L_I;
    end else begin
      done_q        <= 1'b0;
      snp_sup_valid <= snp_take;
      snp_sup_data  <= dat_q[s_idx];

      if (snp_valid && s_hit) begin
        case (snp_type)
          T_RD:        if (s_st == L_M) st_q[s_idx] <= L_S;
          T_WR, T_INV: st_q[s_idx] <= L_I;
          default:     ;
        endcase
      end

      case (fsm_q)
        F_IDLE: if (accept) begin
          if (c_hit) begin
            if (!cpu_req_write) begin
              done_q    <= 1'b1;
              cpu_rdata <= dat_q[c_idx];
            end else if (c_st == L_M) begin
              done_q <= 1'b1;
            end else begin
              fsm_q <= F_UPG;
            end
          end else begin
            fsm_q <= (c_st == L_M) ? F_WB : F_MISS;
          end
        end
        F_WB: begin
          if (abort) fsm_q <= F_IDLE;
          else if (issue) begin
            st_q[c_idx] <= L_I;
            fsm_q       <= F_MISS;
          end
        end
        F_MISS: begin
          if (abort) fsm_q <= F_IDLE;
          else if (issue) begin
            st_q[c_idx] <= L_I;
            fsm_q       <= F_FILL;
          end
        end
        F_FILL: if (fill_valid) begin
          st_q[c_idx] <= cpu_req_write ? L_M : L_S;
          cpu_rdata   <= fill_data;
          done_q      <= 1'b1;
          fsm_q       <= F_IDLE;
        end
        F_UPG: begin
          if (abort) fsm_q <= F_IDLE;
          else if (issue) begin
            st_q[c_idx] <= L_M;
            done_q      <= 1'b1;
            fsm_q       <= F_IDLE;
          end
        end
        default: fsm_q <= F_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (fsm_q == F_MISS && issue) tag_q[c_idx] <= c_tag;
    if (accept && c_hit && cpu_req_write && c_st == L_M) dat_q[c_idx] <= cpu_req_wdata;
    if (fsm_q == F_UPG && issue) dat_q[c_idx] <= cpu_req_wdata;
    if (fsm_q == F_FILL && fill_valid)
      dat_q[c_idx] <= cpu_req_write ? cpu_req_wdata : fill_data;
  end

endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_ready,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic       bus_cmd_valid,
  input logic [1:0] bus_cmd_type,
  input logic       snp_valid,
  input logic [1:0] snp_type,
  input logic       snp_own_m,
  input logic       snp_sup_valid
);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !bus_req && !cpu_ready && !snp_sup_valid);

  p_inv_then_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_valid && bus_cmd_type == 2'd2 |=> cpu_ready);

  p_wb_then_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_valid && bus_cmd_type == 2'd3 |=> bus_req);

  p_supply_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    snp_own_m && (snp_type == 2'd0 || snp_type == 2'd1) |=> snp_sup_valid);

  p_snoop_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !bus_cmd_valid);

  p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt && !snp_valid |=> bus_req);

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !cpu_ready);

  p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .bus_req(bus_req),
  .bus_gnt(bus_gnt), .bus_cmd_valid(bus_cmd_valid), .bus_cmd_type(bus_cmd_type),
  .snp_valid(snp_valid), .snp_type(snp_type), .snp_own_m(snp_own_m),
  .snp_sup_valid(snp_sup_valid)
);

// File: tb/test_msi_snoop_ctrl.sv
module test_msi_snoop_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;
  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_SN = 2'd2;
  localparam logic [2:0] C_RD = 3'd0, C_WR = 3'd1, C_INV = 3'd2, C_WB = 3'd3, C_NO = 3'd4;
  localparam logic [15:0] AA = 16'h0010, AB = 16'h0018, AC = 16'h0021;

  typedef struct packed {
    logic [1:0]  kind;
    logic [1:0]  stype;
    logic [15:0] addr;
    logic [31:0] wdata;
    logic [2:0]  c0;
    logic [2:0]  c1;
    logic [31:0] exp_rd;
    logic [31:0] exp_bus;
    logic [7:0]  rid;
  } vec_t;

  // c0 of a snoop vector: 1 = supply expected
  localparam vec_t VECS [NV] = '{
    '{K_RD, 2'd0, AA, 32'h0,        C_RD,  C_NO, 32'hCAFE0010, 32'h0,        8'd2}, // R2
    '{K_RD, 2'd0, AA, 32'h0,        C_NO,  C_NO, 32'hCAFE0010, 32'h0,        8'd4}, // R4
    '{K_WR, 2'd0, AA, 32'h11111111, C_INV, C_NO, 32'h0,        32'h0,        8'd3}, // R3
    '{K_RD, 2'd0, AA, 32'h0,        C_NO,  C_NO, 32'h11111111, 32'h0,        8'd4}, // R4
    '{K_WR, 2'd0, AA, 32'h22222222, C_NO,  C_NO, 32'h0,        32'h0,        8'd4}, // R4
    '{K_RD, 2'd0, AB, 32'h0,        C_WB,  C_RD, 32'hCAFE0018, 32'h22222222, 8'd5}, // R5
    '{K_WR, 2'd0, AC, 32'h33333333, C_WR,  C_NO, 32'h0,        32'h0,        8'd5}, // R5
    '{K_SN, 2'd0, AC, 32'h0,        3'd1,  C_NO, 32'h0,        32'h33333333, 8'd6}, // R6
    '{K_WR, 2'd0, AC, 32'h44444444, C_INV, C_NO, 32'h0,        32'h0,        8'd6}, // R6
    '{K_SN, 2'd1, AC, 32'h0,        3'd1,  C_NO, 32'h0,        32'h44444444, 8'd7}, // R7
    '{K_RD, 2'd0, AC, 32'h0,        C_RD,  C_NO, 32'hCAFE0021, 32'h0,        8'd7}, // R7
    '{K_SN, 2'd2, AC, 32'h0,        3'd0,  C_NO, 32'h0,        32'h0,        8'd7}, // R7
    '{K_RD, 2'd0, AC, 32'h0,        C_RD,  C_NO, 32'hCAFE0021, 32'h0,        8'd7}, // R7
    '{K_SN, 2'd0, AB, 32'h0,        3'd0,  C_NO, 32'h0,        32'h0,        8'd8}, // R8
    '{K_RD, 2'd0, AB, 32'h0,        C_NO,  C_NO, 32'hCAFE0018, 32'h0,        8'd8}, // R8
    '{K_SN, 2'd1, AA, 32'h0,        3'd0,  C_NO, 32'h0,        32'h0,        8'd8}, // R8
    '{K_RD, 2'd0, AB, 32'h0,        C_NO,  C_NO, 32'hCAFE0018, 32'h0,        8'd8}, // R8
    '{K_WR, 2'd0, AB, 32'h55555555, C_INV, C_NO, 32'h0,        32'h0,        8'd3}, // R3
    '{K_WR, 2'd0, AA, 32'h66666666, C_WB,  C_WR, 32'h0,        32'h55555555, 8'd5}, // R5
    '{K_SN, 2'd2, AB, 32'h0,        3'd0,  C_NO, 32'h0,        32'h0,        8'd8}, // R8
    '{K_RD, 2'd0, AA, 32'h0,        C_NO,  C_NO, 32'h66666666, 32'h0,        8'd4}  // R4
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [15:0] cpu_req_addr = '0;
  logic [31:0] cpu_req_wdata = '0;
  logic cpu_ready, bus_req, bus_cmd_valid, snp_sup_valid;
  logic [31:0] cpu_rdata, bus_cmd_data, snp_sup_data;
  logic [1:0] bus_cmd_type;
  logic [15:0] bus_cmd_addr;
  logic bus_gnt = 1'b0, fill_valid = 1'b0, snp_valid = 1'b0;
  logic [31:0] fill_data = '0;
  logic [1:0] snp_type = '0;
  logic [15:0] snp_addr = '0;

  int checks = 0, fails = 0, cyc = 0;

  msi_snoop_ctrl i_msi_snoop_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_valid(bus_cmd_valid),
    .bus_cmd_type(bus_cmd_type), .bus_cmd_addr(bus_cmd_addr), .bus_cmd_data(bus_cmd_data),
    .fill_valid(fill_valid), .fill_data(fill_data), .snp_valid(snp_valid), .snp_type(snp_type),
    .snp_addr(snp_addr), .snp_sup_valid(snp_sup_valid), .snp_sup_data(snp_sup_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog R10: cycles %0d expected below 20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic cpu_start(input logic wr, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = d;
  endtask

  task automatic cpu_finish(output logic [2:0] c0, output logic [2:0] c1,
                            output logic [31:0] wbd, output logic [31:0] rd);
    int n = 0;
    bit pend = 0;
    bit fin = 0;
    c0 = C_NO; c1 = C_NO; wbd = '0; rd = '0;
    for (int k = 0; k < 60 && !fin; k++) begin
      @(negedge clk);
      bus_gnt = 1'b0; fill_valid = 1'b0;
      if (cpu_ready) begin
        rd = cpu_rdata; fin = 1; cpu_req_valid = 1'b0;
      end else if (pend) begin
        fill_valid = 1'b1; fill_data = {16'hCAFE, cpu_req_addr}; pend = 0;
      end else if (bus_req) begin
        bus_gnt = 1'b1;
        #1;
        if (bus_cmd_valid) begin
          if (n == 0) c0 = {1'b0, bus_cmd_type}; else c1 = {1'b0, bus_cmd_type};
          n++;
          if (bus_cmd_type == 2'd3) wbd = bus_cmd_data;
          if (bus_cmd_type <= 2'd1) pend = 1;
        end
      end
    end
    chk(fin, "R10 request completion", 32'(fin), 32'd1);
  endtask

  task automatic snoop(input logic [1:0] t, input logic [15:0] a,
                       output logic sv, output logic [31:0] sd);
    @(negedge clk);
    snp_valid = 1'b1; snp_type = t; snp_addr = a;
    @(negedge clk);
    snp_valid = 1'b0;
    sv = snp_sup_valid; sd = snp_sup_data;
  endtask

  initial begin
    logic [2:0] g0, g1;
    logic [31:0] gwb, grd;
    logic sv;
    logic [31:0] sd;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!cpu_ready, "R1 cpu_ready in reset", 32'(cpu_ready), 32'd0);
    chk(!bus_req, "R1 bus_req in reset", 32'(bus_req), 32'd0);
    chk(!snp_sup_valid, "R1 supply in reset", 32'(snp_sup_valid), 32'd0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      t = VECS[v];
      if (t.kind == K_SN) begin
        snoop(t.stype, t.addr, sv, sd);
        chk(sv == t.c0[0], $sformatf("R%0d vec %0d supply valid", t.rid, v), 32'(sv), 32'(t.c0[0]));
        if (t.c0[0]) chk(sd == t.exp_bus, $sformatf("R%0d vec %0d supply data", t.rid, v), sd, t.exp_bus);
      end else begin
        cpu_start(t.kind == K_WR, t.addr, t.wdata);
        cpu_finish(g0, g1, gwb, grd);
        chk(g0 == t.c0, $sformatf("R%0d vec %0d first bus cmd", t.rid, v), 32'(g0), 32'(t.c0));
        chk(g1 == t.c1, $sformatf("R%0d vec %0d second bus cmd", t.rid, v), 32'(g1), 32'(t.c1));
        if (t.kind == K_RD) chk(grd == t.exp_rd, $sformatf("R%0d vec %0d read data", t.rid, v), grd, t.exp_rd);
        if (t.c0 == C_WB) chk(gwb == t.exp_bus, $sformatf("R%0d vec %0d write back data", t.rid, v), gwb, t.exp_bus);
      end
    end

    // R9: grant and invalidate snoop in the same cycle while an upgrade of C waits
    cpu_start(1'b1, AC, 32'h77777777);
    @(negedge clk);
    chk(bus_req, "R10 upgrade requests bus", 32'(bus_req), 32'd1);
    bus_gnt = 1'b1; snp_valid = 1'b1; snp_type = 2'd2; snp_addr = AC;
    #1;
    chk(!bus_cmd_valid, "R9 no command under snoop", 32'(bus_cmd_valid), 32'd0);
    @(negedge clk);
    bus_gnt = 1'b0; snp_valid = 1'b0;
    cpu_finish(g0, g1, gwb, grd);
    chk(g0 == C_WR, "R9 retried upgrade becomes write miss", 32'(g0), 32'(C_WR));
    chk(g1 == C_NO, "R9 single retry command", 32'(g1), 32'(C_NO));
    cpu_start(1'b0, AC, 32'h0);
    cpu_finish(g0, g1, gwb, grd);
    chk(g0 == C_NO, "R9 later read hits", 32'(g0), 32'(C_NO));
    chk(grd == 32'h77777777, "R9 later read data", grd, 32'h77777777);

    // R9: snoop delays acceptance of a read hit by one cycle
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = AA;
    snp_valid = 1'b1; snp_type = 2'd0; snp_addr = 16'h0042;
    @(negedge clk);
    snp_valid = 1'b0;
    chk(!cpu_ready, "R9 request held during snoop", 32'(cpu_ready), 32'd0);
    @(negedge clk);
    chk(cpu_ready, "R9 request done after snoop", 32'(cpu_ready), 32'd1);
    chk(cpu_rdata == 32'h66666666, "R9 read data after snoop", cpu_rdata, 32'h66666666);
    cpu_req_valid = 1'b0;
    @(negedge clk);
    chk(!cpu_ready, "R11 ready is one pulse", 32'(cpu_ready), 32'd0);

    // R1: reset mid-run invalidates every line
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cpu_start(1'b0, AA, 32'h0);
    cpu_finish(g0, g1, gwb, grd);
    chk(g0 == C_RD, "R1 read after reset misses", 32'(g0), 32'(C_RD));
    chk(grd == 32'hCAFE0010, "R1 read after reset data", grd, 32'hCAFE0010);
    cpu_start(1'b0, AC, 32'h0);
    cpu_finish(g0, g1, gwb, grd);
    chk(g0 == C_RD, "R1 second line invalid after reset", 32'(g0), 32'(C_RD));

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule